// File: doc/BRIEF.md
# Universal Shift and Storage Register with Shared Parallel Pins

This block is an eight-bit register that can keep its contents, shift toward the high bit, shift toward the low bit, or take a new word in parallel. A two-bit mode input selects which of these four actions happens on each rising clock edge. Each end of the register has its own serial input. Each end bit also drives a dedicated tap output that is always on, so several copies can be chained into a longer shift word.

The parallel data path uses one set of bidirectional pins. For synthesis, each pin is split into a data input, a data output and one shared output-enable. The output-enable goes low when either of two active-low enables is high. It also goes low whenever load mode is selected, so that the pins can carry input data during a load. Whether the drivers are on has no effect on the register's operation. An active-low clear empties the register at once, without waiting for the clock.

Top module: `univ_shift_reg`

## Requirements
- R1: With mode_sel = 2'b00, a rising clock edge leaves all bits unchanged, whatever the values on pin_in and on the serial inputs.
- R2: With mode_sel = 2'b01, a rising edge moves ser_in_lo into bit 0 and bit i into bit i+1 for i = 0..6. The old bit 7 is dropped.
- R3: With mode_sel = 2'b10, a rising edge moves ser_in_hi into bit 7 and bit i+1 into bit i for i = 0..6. The old bit 0 is dropped.
- R4: With mode_sel = 2'b11, a rising edge copies pin_in into the register, with pin_in[i] going to bit i.
- R5: While rst_n is low, all bits read zero without waiting for a clock edge, whatever mode_sel is set to.
- R6: pin_oe is 0 whenever oe_a_n or oe_b_n is 1.
- R7: pin_oe is 0 whenever mode_sel = 2'b11. When both enables are 0 and mode_sel is not 2'b11, pin_oe is 1.
- R8: Hold, shift, load and clear work the same way while pin_oe is 0. pin_out always carries the register contents.
- R9: tap_lo always equals bit 0 and tap_hi always equals bit 7, whatever the enables are set to.
- R10: Two instances chained (the low instance's tap_hi drives the high instance's ser_in_lo, and the high instance's tap_lo drives the low instance's ser_in_hi) act as one 16-bit register under all four modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Active-low clear, acts without the clock |
| mode_sel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_in_hi | input | 1 | Serial bit entering bit 7 on a downward shift |
| oe_a_n | input | 1 | First active-low driver enable |
| oe_b_n | input | 1 | Second active-low driver enable |
| pin_in | input | 8 | Data-in side of the shared parallel pins |
| pin_out | output | 8 | Data-out side of the shared pins; always the register contents |
| pin_oe | output | 1 | Driver enable for the shared pins |
| tap_lo | output | 1 | Bit 0 serial tap, always driven |
| tap_hi | output | 1 | Bit 7 serial tap, always driven |

## Verification
Register results (hold, both shifts, load) are due on the first rising edge after the mode and data are applied. pin_oe and the two taps are combinational and follow their inputs in the same cycle. The clear shows on the outputs without any clock edge. The bench drives inputs on the falling edge and reads register results on the next falling edge. It checks pin_oe and the clear a short delay after driving, before any rising edge. Two chained instances are compared every cycle against a 16-bit reference model, including random mode runs with clears mid-sequence.

// File: rtl/usr_pkg.sv
// Shared types for the universal shift register.
// Assumes a two-bit mode encoding that is fixed by the pin-level behaviour.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_mode_dec.sv
// Decodes the raw mode pins and forms the parallel driver enable.
// Assumes both enables are active low. The driver enable is purely
// combinational, so it drops in the same cycle that load is selected.
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output usr_mode_e  mode,
    output logic       drv_en
);
    // Map the raw pins onto the mode type and gate the driver.
    always_comb begin
        mode   = usr_mode_e'(mode_sel);
        drv_en = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);
    end
endmodule

// File: rtl/usr_bit_cell.sv
// One storage bit with its four-way next-state selector.
// Assumes the parent wires from_lo and from_hi to the neighbouring bits,
// or to the serial inputs at the ends. The clear is asynchronous and active low.
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  usr_mode_e mode,
    input  logic      from_lo,
    input  logic      from_hi,
    input  logic      par_in,
    output logic      q
);
    logic nxt;

    // Choose the next value of this bit from the selected mode.
    always_comb begin
        unique case (mode)
            MODE_HOLD: nxt = q;
            MODE_UP:   nxt = from_lo;
            MODE_DOWN: nxt = from_hi;
            MODE_LOAD: nxt = par_in;
            default:   nxt = q;
        endcase
    end

    // Store the bit; the clear overrides the clock and the mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end
endmodule

// File: rtl/univ_shift_reg.sv
// Universal shift/storage register with a shared parallel data path.
// Each shared pin is split into pin_in, pin_out and a common pin_oe.
// The end bits are always brought out as serial taps for cascading.
// Assumes WIDTH >= 2.
module univ_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe,
    output logic             tap_lo,
    output logic             tap_hi
);
    localparam int MSB = WIDTH - 1;

    usr_mode_e        mode;
    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] lo_src;
    logic [WIDTH-1:0] hi_src;

    usr_mode_dec u_dec (
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .mode     (mode),
        .drv_en   (pin_oe)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Lower neighbour: serial input for bit 0, else the bit below.
        if (i == 0) begin : g_lo_end
            assign lo_src[i] = ser_in_lo;
        end else begin : g_lo_mid
            assign lo_src[i] = state[i-1];
        end
        // Upper neighbour: serial input for the top bit, else the bit above.
        if (i == MSB) begin : g_hi_end
            assign hi_src[i] = ser_in_hi;
        end else begin : g_hi_mid
            assign hi_src[i] = state[i+1];
        end

        usr_bit_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode),
            .from_lo (lo_src[i]),
            .from_hi (hi_src[i]),
            .par_in  (pin_in[i]),
            .q       (state[i])
        );
    end

    // Bring the contents and end bits out; the taps ignore the enables.
    always_comb begin
        pin_out = state;
        tap_lo  = state[0];
        tap_hi  = state[MSB];
    end
endmodule

// File: rtl/usr_checker.sv
// Property checker for univ_shift_reg, attached by bind.
// Assumes the clear is held across at least one rising edge.
module usr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             ser_in_lo,
    input logic             ser_in_hi,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic             pin_oe,
    input logic             tap_lo,
    input logic             tap_hi
);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> $stable(pin_out));
    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01) |=> pin_out == {$past(pin_out[WIDTH-2:0]), $past(ser_in_lo)});
    // R3
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10) |=> pin_out == {$past(ser_in_hi), $past(pin_out[WIDTH-1:1])});
    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |=> pin_out == $past(pin_in));
    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_a_n || oe_b_n) |-> !pin_oe);
    // R7
    load_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b11) |-> !pin_oe);
    // R7
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> pin_oe);
    // R9
    tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_lo == pin_out[0]) && (tap_hi == pin_out[WIDTH-1]));
endmodule

bind univ_shift_reg usr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .tap_lo    (tap_lo),
    .tap_hi    (tap_hi)
);

// File: tb/sim_univ_shift_reg.sv
`timescale 1ns/1ps
// Directed bench: two chained instances form a 16-bit word checked
// against a reference model. Inputs change on falling edges.
module sim_univ_shift_reg;
    localparam int W  = 8;
    localparam int W2 = 2 * W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic [1:0]    mode_sel;
    logic          ser_lo, ser_hi, oe_a_n, oe_b_n;
    logic [W2-1:0] pin_in;
    logic [W-1:0]  po0, po1;
    logic          pe0, pe1, tl0, th0, tl1, th1;
    logic [W2-1:0] model;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    univ_shift_reg #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ser_in_lo(ser_lo),
        .ser_in_hi(tl1), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_in[W-1:0]),
        .pin_out(po0), .pin_oe(pe0), .tap_lo(tl0), .tap_hi(th0));
    univ_shift_reg #(.WIDTH(W)) u1 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ser_in_lo(th0),
        .ser_in_hi(ser_hi), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_in[W2-1:W]),
        .pin_out(po1), .pin_oe(pe1), .tap_lo(tl1), .tap_hi(th1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare contents and all four taps with the model.
    task automatic chk_state(input string tag);
        chk(tag, {po1, po0}, model);
        chk({tag, " R9 taps"}, {th1, tl1, th0, tl0},
            {model[W2-1], model[W], model[W-1], model[0]});
    endtask

    // One clocked cycle: drive at the falling edge, check at the next one.
    task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                        input logic [W2-1:0] pi, input string tag);
        mode_sel = m; ser_lo = sl; ser_hi = sh; pin_in = pi;
        case (m)
            2'b00: model = model;
            2'b01: model = {model[W2-2:0], sl};
            2'b10: model = {sh, model[W2-1:1]};
            default: model = pi;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk_state(tag);
    endtask

    task automatic t_reset_state();
        chk("R5 reset state", {po1, po0}, 32'h0);
        mode_sel = 2'b00; #1;
        chk("R7 drivers on in hold", {pe1, pe0}, 2'b11);
        @(negedge clk);
    endtask

    task automatic t_load();
        step(2'b11, 1'b0, 1'b0, 16'hA55A, "R4 load A55A");
        step(2'b11, 1'b1, 1'b1, 16'h0FF0, "R4 load 0FF0");
        mode_sel = 2'b11; #1;
        chk("R7 drivers off in load", {pe1, pe0}, 2'b00);
        @(negedge clk);
    endtask

    task automatic t_hold();
        step(2'b00, 1'b1, 1'b1, 16'hFFFF, "R1 hold pins high");
        step(2'b00, 1'b0, 1'b1, 16'h1234, "R1 hold pins mixed");
        step(2'b00, 1'b1, 1'b0, 16'h0000, "R1 hold pins low");
    endtask

    task automatic t_up();
        step(2'b11, 1'b0, 1'b0, 16'h0081, "R4 preload 0081");
        step(2'b01, 1'b1, 1'b0, 16'hFFFF, "R2 up in 1 / R10 carry");
        step(2'b01, 1'b0, 1'b1, 16'h0000, "R2 up in 0");
        for (int i = 0; i < 14; i++) step(2'b01, i[0], 1'b0, 16'h0, "R10 up chain");
    endtask

    task automatic t_down();
        step(2'b11, 1'b0, 1'b0, 16'h8100, "R4 preload 8100");
        step(2'b10, 1'b0, 1'b1, 16'hFFFF, "R3 down in 1 / R10 carry");
        step(2'b10, 1'b1, 1'b0, 16'h0000, "R3 down in 0");
        for (int i = 0; i < 14; i++) step(2'b10, 1'b0, i[1], 16'h0, "R10 down chain");
    endtask

    task automatic t_oe();
        oe_a_n = 1'b1; oe_b_n = 1'b0; mode_sel = 2'b00; #1;
        chk("R6 enable a off", {pe1, pe0}, 2'b00);
        oe_a_n = 1'b0; oe_b_n = 1'b1; #1;
        chk("R6 enable b off", {pe1, pe0}, 2'b00);
        oe_a_n = 1'b1; #1;
        chk("R6 both off", {pe1, pe0}, 2'b00);
        @(negedge clk);
        step(2'b11, 1'b0, 1'b0, 16'hC3E1, "R8 load drivers off");
        step(2'b01, 1'b1, 1'b0, 16'h0, "R8 up drivers off");
        step(2'b10, 1'b0, 1'b1, 16'h0, "R8 down drivers off");
        step(2'b00, 1'b1, 1'b1, 16'hFFFF, "R8 hold drivers off");
        oe_a_n = 1'b0; oe_b_n = 1'b0; #1;
        chk("R7 drivers back on", {pe1, pe0}, 2'b11);
        @(negedge clk);
    endtask

    task automatic t_clear();
        step(2'b11, 1'b0, 1'b0, 16'hFFFF, "R4 preload FFFF");
        #1; mode_sel = 2'b11; pin_in = 16'hFFFF; rst_n = 1'b0; model = '0;
        #0.5;
        chk("R5 clear without clock", {po1, po0}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk_state("R5 clear overrides load");
        rst_n = 1'b1;
        step(2'b00, 1'b0, 1'b0, 16'h0, "R5 after clear");
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 19) == 0) begin
                rst_n = 1'b0; model = '0; #1;
                chk("R5 random clear", {po1, po0}, 32'h0);
                @(posedge clk); @(negedge clk);
                rst_n = 1'b1;
            end else begin
                step(2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), "R10 random");
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 2'b00; ser_lo = 1'b0; ser_hi = 1'b0;
        oe_a_n = 1'b0; oe_b_n = 1'b0; pin_in = '0; model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_load();
        t_hold();
        t_up();
        t_down();
        t_oe();
        t_clear();
        t_random();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule